// File: doc/BRIEF.md
# Line APS and Defect Byte Monitor

This block watches the two automatic protection switching overhead bytes of each received frame. A valid strobe marks each frame. The 13-bit protection code is built from the whole first byte and the upper five bits of the second byte. The remaining three status bits of the second byte are tracked on their own path. Each path takes a new value only after that value has arrived unchanged in a programmable number of back-to-back frames. This keeps single-frame corruption away from the protection logic that reads the outputs.

The accepted status field is decoded into two line defect flags:
- Line AIS is set while the status code is 3'b111.
- Line RDI is set while the status code is 3'b110.

Four sticky change bits record every change of the protection code, the status code, the AIS flag and the RDI flag. Each bit is cleared by writing 1 to it. Any unmasked sticky bit drives the interrupt line. A host can also mask everything and poll the bits.

Top module: `aps_defect_mon`

## Requirements
- R1: The protection code output equals {K1[7:0], K2[7:3]}. It takes a new value only after that value has arrived in T consecutive valid frames, where T = persist_n_i, or 1 when persist_n_i is 0. It updates on the clock edge that samples the T-th such frame.
- R2: A valid frame whose field differs from the previous valid frame's field restarts the run count at 1 for that field.
- R3: The status output follows K2[2:0] through its own independent filter with the same rule. A change on one field never changes the other field's output or sets the other field's change bit.
- R4: ais_o is 1 exactly when the accepted status is 3'b111. rdi_o is 1 exactly when the accepted status is 3'b110.
- R5: Change bits are evt_o[0] for the protection code, evt_o[1] for the status code, evt_o[2] for AIS and evt_o[3] for RDI. A bit is set on the same edge that its item's output changes, and it stays set until cleared.
- R6: Writing 1 to a bit of evt_clr_i for one cycle clears that change bit and leaves the other bits alone. A set that occurs in the same cycle takes priority over the clear.
- R7: irq_o is the OR of the change bits whose evt_mask_i bit is 0.
- R8: Cycles with frame_vld_i low change no output and no change bit, whatever the byte inputs carry.
- R9: After reset, both accepted values, both defect flags, all change bits and irq_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_vld_i | input | 1 | One-cycle strobe marking a received frame's bytes |
| k1_i | input | 8 | First protection byte |
| k2_i | input | 8 | Second protection byte |
| persist_n_i | input | CNT_W | Number of consecutive identical frames needed for acceptance |
| evt_mask_i | input | 4 | Interrupt mask, 1 blocks the bit |
| evt_clr_i | input | 4 | Write-1-to-clear strobes for the change bits |
| aps_o | output | 13 | Accepted protection code |
| stat_o | output | 3 | Accepted status code |
| ais_o | output | 1 | Line AIS defect |
| rdi_o | output | 1 | Line RDI defect |
| evt_o | output | 4 | Sticky change bits |
| irq_o | output | 1 | Interrupt |

## Verification
The bench uses the default counter width of 4 bits and sweeps the persistence setting from 0 to 6. This covers the single-frame acceptance that applies to settings 0 and 1, and every run length from 1 to 6. For each setting it checks that the code output holds its old value for every frame before the T-th and changes exactly on the T-th frame. From setting 2 upward it also checks that a run broken by one differing frame must start again. A fixed threshold of 3 then walks the status field through the AIS code, the RDI code, the idle code and a non-defect code. This exercises the defect decode, the independence of the two filters and every combination of masking and clearing.

// File: rtl/aps_mon_pkg.sv
package aps_mon_pkg;
  localparam int unsigned APS_W  = 13;
  localparam int unsigned STAT_W = 3;
  localparam int unsigned EVT_N  = 4;
  localparam int unsigned EV_APS  = 0;
  localparam int unsigned EV_STAT = 1;
  localparam int unsigned EV_AIS  = 2;
  localparam int unsigned EV_RDI  = 3;
  localparam logic [STAT_W-1:0] CODE_AIS = 3'b111;
  localparam logic [STAT_W-1:0] CODE_RDI = 3'b110;
endpackage

// File: rtl/aps_persist_filt.sv
module aps_persist_filt #(
  parameter int unsigned W     = 13,
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic [W-1:0]     din_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic [W-1:0]     acc_o,
  output logic             upd_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [W-1:0]     cand_q, acc_q;
  logic [CNT_W-1:0] cnt_q, run_nxt;

  always_comb begin
    if (din_i == cand_q) run_nxt = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CNT_ONE;
    else                 run_nxt = CNT_ONE;
    upd_o = vld_i && (run_nxt >= thr_i) && (din_i != acc_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cand_q <= '0;
      cnt_q  <= '0;
      acc_q  <= '0;
    end else if (vld_i) begin
      cand_q <= din_i;
      cnt_q  <= run_nxt;
      if (upd_o) acc_q <= din_i;
    end
  end

  assign acc_o = acc_q;

  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> $stable(acc_o) && $stable(cnt_q));
  // R2
  run_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && din_i != cand_q) |=> cnt_q == CNT_ONE);
  // R1
  accept_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_o != $past(acc_o)) |-> ($past(vld_i) && cnt_q >= $past(thr_i) && acc_o == cand_q));
endmodule

// File: rtl/aps_evt_reg.sv
module aps_evt_reg #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] evt_o,
  output logic         irq_o
);
  logic [N-1:0] evt_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       evt_q[i] <= 1'b0;
      else if (set_i[i]) evt_q[i] <= 1'b1;
      else if (clr_i[i]) evt_q[i] <= 1'b0;
    end

    // R6
    w1c_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && !set_i[i]) |=> !evt_o[i]);
    // R5
    sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt_o[i] && !clr_i[i]) |=> evt_o[i]);
  end

  assign evt_o = evt_q;
  assign irq_o = |(evt_q & ~mask_i);
endmodule

// File: rtl/aps_defect_mon.sv
module aps_defect_mon
  import aps_mon_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_vld_i,
  input  logic [7:0]        k1_i,
  input  logic [7:0]        k2_i,
  input  logic [CNT_W-1:0]  persist_n_i,
  input  logic [EVT_N-1:0]  evt_mask_i,
  input  logic [EVT_N-1:0]  evt_clr_i,
  output logic [APS_W-1:0]  aps_o,
  output logic [STAT_W-1:0] stat_o,
  output logic              ais_o,
  output logic              rdi_o,
  output logic [EVT_N-1:0]  evt_o,
  output logic              irq_o
);
  logic [CNT_W-1:0]  thr;
  logic [APS_W-1:0]  aps_in;
  logic [STAT_W-1:0] stat_in;
  logic              upd_aps, upd_stat;
  logic [EVT_N-1:0]  evt_set;

  assign thr     = (persist_n_i == '0) ? CNT_W'(1) : persist_n_i;
  assign aps_in  = {k1_i, k2_i[7:3]};
  assign stat_in = k2_i[2:0];

  aps_persist_filt #(.W(APS_W), .CNT_W(CNT_W)) u_aps_filt (
    .clk_i, .rst_ni, .vld_i(frame_vld_i), .din_i(aps_in), .thr_i(thr),
    .acc_o(aps_o), .upd_o(upd_aps)
  );

  aps_persist_filt #(.W(STAT_W), .CNT_W(CNT_W)) u_stat_filt (
    .clk_i, .rst_ni, .vld_i(frame_vld_i), .din_i(stat_in), .thr_i(thr),
    .acc_o(stat_o), .upd_o(upd_stat)
  );

  assign ais_o = (stat_o == CODE_AIS);
  assign rdi_o = (stat_o == CODE_RDI);

  always_comb begin
    evt_set          = '0;
    evt_set[EV_APS]  = upd_aps;
    evt_set[EV_STAT] = upd_stat;
    evt_set[EV_AIS]  = upd_stat && ((stat_in == CODE_AIS) != ais_o);
    evt_set[EV_RDI]  = upd_stat && ((stat_in == CODE_RDI) != rdi_o);
  end

  aps_evt_reg #(.N(EVT_N)) u_evt (
    .clk_i, .rst_ni, .set_i(evt_set), .clr_i(evt_clr_i), .mask_i(evt_mask_i),
    .evt_o, .irq_o
  );

  // R5
  aps_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aps_o != $past(aps_o)) |-> evt_o[EV_APS]);
  // R5
  ais_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ais_o != $past(ais_o)) |-> evt_o[EV_AIS]);
  // R4
  defect_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ais_o && rdi_o));
  // R3
  aps_indep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aps_o != $past(aps_o)) |-> $past(aps_in) == aps_o);
endmodule

// File: tb/aps_defect_mon_bench.sv
module aps_defect_mon_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 4;

  logic        clk = 0, rst_ni = 0, vld = 0;
  logic [7:0]  k1 = 0, k2 = 0;
  logic [CNT_W-1:0] pn = 0;
  logic [3:0]  mask = 0, clr = 0;
  logic [12:0] aps;
  logic [2:0]  stat;
  logic        ais, rdi, irq;
  logic [3:0]  evt;
  int n_chk = 0, n_bad = 0;
  logic [12:0] cur_aps = 0;
  logic [2:0]  cur_st = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aps_defect_mon #(.CNT_W(CNT_W)) u_aps_defect_mon (
    .clk_i(clk), .rst_ni, .frame_vld_i(vld), .k1_i(k1), .k2_i(k2),
    .persist_n_i(pn), .evt_mask_i(mask), .evt_clr_i(clr),
    .aps_o(aps), .stat_o(stat), .ais_o(ais), .rdi_o(rdi), .evt_o(evt), .irq_o(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [12:0] a, input logic [2:0] s);
    @(negedge clk);
    vld = 1; k1 = a[12:5]; k2 = {a[4:0], s};
    @(negedge clk);
    vld = 0;
  endtask

  task automatic wclr(input logic [3:0] b);
    @(negedge clk);
    clr = b;
    @(negedge clk);
    clr = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 aps", int'(aps), 0);
    chk("R9 stat", int'(stat), 0);
    chk("R9 defects", int'({ais, rdi}), 0);
    chk("R9 evt", int'(evt), 0);
    chk("R9 irq", int'(irq), 0);
    rst_ni = 1;
    @(negedge clk);

    for (int n = 0; n <= 6; n++) begin
      int thr;
      logic [12:0] a, b, prev;
      thr = (n == 0) ? 1 : n;
      pn = CNT_W'(n);
      a = 13'(n * 256 + 53 + n);
      prev = cur_aps;
      for (int j = 1; j <= thr; j++) begin
        send(a, cur_st);
        chk($sformatf("R1 n=%0d frame %0d", n, j), int'(aps), int'((j >= thr) ? a : prev));
      end
      cur_aps = a;
      chk("R5 aps evt", int'(evt), 1);
      chk("R3 stat unchanged", int'(stat), int'(cur_st));
      wclr(4'b0001);
      chk("R6 aps evt cleared", int'(evt), 0);
      if (n >= 2) begin
        b = a ^ 13'h1fff;
        for (int j = 0; j < thr - 1; j++) send(b, cur_st);
        send(a, cur_st);
        for (int j = 0; j < thr - 1; j++) send(b, cur_st);
        chk($sformatf("R2 broken run n=%0d", n), int'(aps), int'(a));
        chk("R2 no evt", int'(evt), 0);
        send(b, cur_st);
        chk($sformatf("R2 completed run n=%0d", n), int'(aps), int'(b));
        cur_aps = b;
        wclr(4'b0001);
      end
    end

    pn = 3;
    // AIS entry
    send(cur_aps, 3'b111);
    send(cur_aps, 3'b111);
    chk("R4 ais pending", int'(ais), 0);
    send(cur_aps, 3'b111);
    chk("R4 ais set", int'({ais, rdi}), 2);
    chk("R5 ais evts", int'(evt), 4'b0110);
    chk("R3 aps kept", int'(aps), int'(cur_aps));
    chk("R7 irq unmasked", int'(irq), 1);
    mask = 4'b1111; #1;
    chk("R7 irq all masked", int'(irq), 0);
    mask = 4'b1011; #1;
    chk("R7 irq ais unmasked", int'(irq), 1);
    wclr(4'b0010);
    chk("R6 single clear", int'(evt), 4'b0100);
    mask = 4'b1101; #1;
    chk("R7 irq masked bit", int'(irq), 0);
    mask = 0;
    wclr(4'b1111);
    // RDI
    for (int j = 0; j < 3; j++) send(cur_aps, 3'b110);
    chk("R4 rdi set", int'({ais, rdi}), 1);
    chk("R5 rdi evts", int'(evt), 4'b1110);
    wclr(4'b1111);
    // back to idle
    for (int j = 0; j < 3; j++) send(cur_aps, 3'b000);
    chk("R4 cleared", int'({ais, rdi}), 0);
    chk("R5 rdi drop evt", int'(evt), 4'b1010);
    wclr(4'b1000);
    chk("R6 clear rdi bit", int'(evt), 4'b0010);
    wclr(4'b1111);

    // R8 invalid cycles ignored
    @(negedge clk);
    k1 = 8'hff; k2 = 8'hff;
    repeat (10) @(negedge clk);
    chk("R8 aps", int'(aps), int'(cur_aps));
    chk("R8 stat", int'(stat), 0);
    chk("R8 evt", int'(evt), 0);

    // R3 status-only change
    for (int j = 0; j < 3; j++) send(cur_aps, 3'b010);
    chk("R3 stat", int'(stat), 2);
    chk("R3 evt only stat", int'(evt), 4'b0010);
    chk("R3 aps", int'(aps), int'(cur_aps));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule